// File: doc/BRIEF.md
# Bus-Snooping Digit Memory with Output Port

This block is a small data memory for a 4-bit processor system. It stores four numeric words of twenty 4-bit digits each and owns one 4-bit output latch. It has no chip-select or strobe wires. It watches a shared, time-multiplexed 4-bit bus, follows the bus cycle phases, and decodes the memory and port commands it sees there by itself. It acts only when the chip field of the current selection matches its own strapped chip number.

A bus cycle has eight phases. A sync pulse marks phase 0. Phases 0 to 2 carry the instruction address and count as the fetch part of the cycle. Phase 3 carries the opcode nibble and phase 4 the operand nibble. Phases 5 to 7 are execute phases. A select command sets a persistent chip, word and digit pointer. Later commands write a digit, read a digit back onto the bus, or load the output port.

A refresh row counter steps once in each fetch phase. It stays still while commands or data can touch the array.

Top module: `snoop_digit_ram`

## Requirements
- R1: Until the first cycle with `syncIn` high, the block decodes no command, drives no bus data and keeps its refresh counter still. The cycle in which `syncIn` is high is phase 0, and each following cycle advances the phase by one, modulo 8.
- R2: An opcode nibble of 0x2 in phase 3 is a select command. The phase 4 nibble holds the chip field in bits 3:2 and the word index in bits 1:0. The phase 5 nibble holds digit bits 3:0, and bit 0 of the phase 6 nibble is digit bit 4. The selection takes effect after phase 6 and persists until the next select command.
- R3: Opcode 0xE with operand 0x0 writes the phase 5 bus nibble into the selected word and digit. It does this only if the selected chip field equals `chipNum`.
- R4: Opcode 0xE with operand 0x9 reads a digit. When the chip is selected, `busOe` is high during phase 5 only and `busOut` carries the stored digit. In every other cycle `busOe` is low and `busOut` is 0.
- R5: Opcode 0xE with operand 0x1 loads the phase 5 nibble into `portOut` when the chip is selected. At all other times `portOut` holds its value.
- R6: When the selected chip field differs from `chipNum`, write, read and port commands have no effect and the bus is not driven.
- R7: A selected digit index of 20 or more is out of range. Writes to it change no stored digit, and reads from it drive 0.
- R8: The refresh row counter (`refreshRow`) advances by one in each of phases 0, 1 and 2, wraps from 3 to 0, and holds during phases 3 to 7.
- R9: Reset clears every stored digit, `portOut`, `refreshRow` and the phase lock. It sets the selection to chip 0, word 0, digit 0.
- R10: An opcode nibble other than 0x2 or 0xE changes no stored digit, does not change the port and does not change the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bus phase per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | High in phase 0 of each bus cycle |
| busIn | input | 4 | Nibble currently on the shared bus |
| chipNum | input | 2 | Strapped chip number this memory answers to |
| busOut | output | 4 | Read data driven onto the bus |
| busOe | output | 1 | Bus drive enable for read data |
| portOut | output | 4 | Output port latch |
| refreshRow | output | 2 | Current refresh row |

## Verification
The bench writes and reads digits at digit 0, at digit 19 (which needs the high digit bit) and in the last word. A wrong address split or a dropped phase 6 bit therefore shows up as a wrong read value. The same commands are repeated with a foreign chip field, which tells strap matching apart from blind decoding. An out-of-range write to digit 21 is followed by a read of word 1, digit 1, which is where a plain linear index would alias, so clipping is separated from wraparound. Bus traffic that arrives before any sync pulse, an unknown opcode placed between a write and its read-back, and a count of refresh steps over many cycles tell phase locking, command filtering and fetch-only refresh apart.

// File: rtl/snoop_digit_ram_pkg.sv
package snoop_digit_ram_pkg;
  localparam int NIB_W    = 4;
  localparam int WORDS    = 4;
  localparam int DIGITS   = 20;
  localparam int PHASES   = 8;
  localparam int CHIP_W   = 2;
  localparam int WORD_W   = $clog2(WORDS);
  localparam int DIG_W    = $clog2(DIGITS);
  localparam int PH_W     = $clog2(PHASES);
  localparam int CELLS    = WORDS * DIGITS;
  localparam int CELL_W   = $clog2(CELLS + 32);
  localparam int ROWS     = WORDS;
  localparam int ROW_W    = $clog2(ROWS);

  // phase positions within one bus cycle
  localparam int FETCH_LAST = 2;
  localparam int PH_OPHI    = 3;
  localparam int PH_OPLO    = 4;
  localparam int PH_EXEC    = 5;
  localparam int PH_EXT     = 6;

  // command codes
  localparam logic [NIB_W-1:0] OP_SELECT  = 4'h2;
  localparam logic [NIB_W-1:0] OP_IO      = 4'hE;
  localparam logic [NIB_W-1:0] SUB_WRDIG  = 4'h0;
  localparam logic [NIB_W-1:0] SUB_WRPORT = 4'h1;
  localparam logic [NIB_W-1:0] SUB_RDDIG  = 4'h9;

  typedef struct packed {
    logic              wrDigit;
    logic              wrPort;
    logic              rdDrive;
    logic [WORD_W-1:0] word;
    logic [DIG_W-1:0]  digit;
  } strobe_t;
endpackage

// File: rtl/snoop_digit_ram_ctl.sv
module snoop_digit_ram_ctl
  import snoop_digit_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [NIB_W-1:0]  busIn,
  input  logic [CHIP_W-1:0] chipNum,
  output strobe_t           stb,
  output logic [PH_W-1:0]   curPhase,
  output logic              locked,
  output logic [ROW_W-1:0]  refreshRow
);
  logic [PH_W-1:0]   phaseCnt;
  logic [NIB_W-1:0]  opHi, opLo;
  logic [CHIP_W-1:0] pendChip, selChip;
  logic [WORD_W-1:0] pendWord, selWord;
  logic [NIB_W-1:0]  pendDigLo;
  logic [DIG_W-1:0]  selDigit;
  logic              phaseValid, isSel, isIo, selected, execNow;

  // phase tracking: sync forces phase 0
  always_comb begin
    curPhase   = syncIn ? '0 : phaseCnt;
    phaseValid = syncIn | locked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      locked   <= 1'b0;
    end else if (phaseValid) begin
      locked   <= 1'b1;
      phaseCnt <= curPhase + PH_W'(1);
    end
  end

  // instruction nibble capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opHi <= '0;
      opLo <= '0;
    end else if (phaseValid) begin
      if (curPhase == PH_W'(PH_OPHI)) opHi <= busIn;
      if (curPhase == PH_W'(PH_OPLO)) opLo <= busIn;
    end
  end

  assign isSel = (opHi == OP_SELECT);
  assign isIo  = (opHi == OP_IO);

  // select command: fields gathered across phases 4..6
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendChip  <= '0;
      pendWord  <= '0;
      pendDigLo <= '0;
      selChip   <= '0;
      selWord   <= '0;
      selDigit  <= '0;
    end else if (phaseValid && isSel) begin
      if (curPhase == PH_W'(PH_OPLO)) begin
        pendChip <= busIn[NIB_W-1 -: CHIP_W];
        pendWord <= busIn[WORD_W-1:0];
      end
      if (curPhase == PH_W'(PH_EXEC)) pendDigLo <= busIn;
      if (curPhase == PH_W'(PH_EXT)) begin
        selChip  <= pendChip;
        selWord  <= pendWord;
        selDigit <= {busIn[DIG_W-NIB_W-1:0], pendDigLo};
      end
    end
  end

  assign selected = (selChip == chipNum);
  assign execNow  = phaseValid && (curPhase == PH_W'(PH_EXEC)) && isIo && selected;

  always_comb begin
    stb.wrDigit = execNow && (opLo == SUB_WRDIG);
    stb.wrPort  = execNow && (opLo == SUB_WRPORT);
    stb.rdDrive = execNow && (opLo == SUB_RDDIG);
    stb.word    = selWord;
    stb.digit   = selDigit;
  end

  // refresh row sequencing: fetch phases only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshRow <= '0;
    end else if (phaseValid && (curPhase <= PH_W'(FETCH_LAST))) begin
      if (refreshRow == ROW_W'(ROWS - 1)) refreshRow <= '0;
      else                                refreshRow <= refreshRow + ROW_W'(1);
    end
  end
endmodule

// File: rtl/snoop_digit_ram_dp.sv
module snoop_digit_ram_dp
  import snoop_digit_ram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] busIn,
  input  strobe_t          stb,
  output logic [NIB_W-1:0] busOut,
  output logic             busOe,
  output logic [NIB_W-1:0] portOut
);
  logic [NIB_W-1:0]  mem [CELLS];
  logic              inRange;
  logic [CELL_W-1:0] cellIdx;

  assign inRange = (int'(stb.digit) < DIGITS);
  assign cellIdx = CELL_W'(int'(stb.word) * DIGITS + int'(stb.digit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= '0;
    end else if (stb.wrDigit && inRange) begin
      mem[cellIdx] <= busIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           portOut <= '0;
    else if (stb.wrPort) portOut <= busIn;
  end

  always_comb begin
    busOe  = stb.rdDrive;
    busOut = '0;
    if (stb.rdDrive && inRange) busOut = mem[cellIdx];
  end
endmodule

// File: rtl/snoop_digit_ram.sv
module snoop_digit_ram
  import snoop_digit_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [NIB_W-1:0]  busIn,
  input  logic [CHIP_W-1:0] chipNum,
  output logic [NIB_W-1:0]  busOut,
  output logic              busOe,
  output logic [NIB_W-1:0]  portOut,
  output logic [ROW_W-1:0]  refreshRow
);
  strobe_t         stb;
  logic [PH_W-1:0] curPhase;
  logic            locked;
  logic            portWrStb;

  snoop_digit_ram_ctl ctl (
    .clk, .rstN, .syncIn, .busIn, .chipNum,
    .stb, .curPhase, .locked, .refreshRow
  );

  snoop_digit_ram_dp dp (
    .clk, .rstN, .busIn, .stb,
    .busOut, .busOe, .portOut
  );

  assign portWrStb = stb.wrPort;
endmodule

// File: rtl/snoop_digit_ram_chk.sv
module snoop_digit_ram_chk
  import snoop_digit_ram_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             syncIn,
  input logic             busOe,
  input logic [NIB_W-1:0] portOut,
  input logic [ROW_W-1:0] refreshRow,
  input logic [PH_W-1:0]  curPhase,
  input logic             locked,
  input logic             portWrStb
);
  assert_drive_exec_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (curPhase == PH_W'(PH_EXEC)));

  assert_no_drive_unlocked_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !syncIn) |-> !busOe);

  assert_refresh_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curPhase > PH_W'(FETCH_LAST)) |=> $stable(refreshRow));

  assert_refresh_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((locked || syncIn) && curPhase <= PH_W'(FETCH_LAST)) |=>
      (refreshRow == (($past(refreshRow) == ROW_W'(ROWS - 1)) ? '0 : $past(refreshRow) + ROW_W'(1))));

  assert_port_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !portWrStb |=> $stable(portOut));
endmodule

bind snoop_digit_ram snoop_digit_ram_chk chk (
  .clk, .rstN, .syncIn, .busOe, .portOut, .refreshRow,
  .curPhase, .locked, .portWrStb
);

// File: tb/snoop_digit_ram_test.sv
`timescale 1ns/100ps
module snoop_digit_ram_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic [3:0] busIn = 4'h0;
  logic [1:0] chipNum = 2'd0;
  logic [3:0] busOut, portOut;
  logic       busOe;
  logic [1:0] refreshRow;

  int checks = 0;
  int failures = 0;
  int refModel = 0;
  logic [3:0] refMem [80];
  logic [3:0] refPort = 4'h0;

  always #2.5 clk = ~clk;

  snoop_digit_ram uut (
    .clk, .rstN, .syncIn, .busIn, .chipNum,
    .busOut, .busOe, .portOut, .refreshRow
  );

  // vector: {pad, op[1:0], chip[1:0], word[1:0], digit[4:0], data[3:0]}
  // op: 0 write digit, 1 read digit, 2 write port
  localparam int NVEC = 16;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 2'd1, 2'd0, 5'd0,  4'h5},
    {1'b0, 2'd0, 2'd1, 2'd0, 5'd19, 4'hA},
    {1'b0, 2'd0, 2'd1, 2'd3, 5'd19, 4'hF},
    {1'b0, 2'd0, 2'd1, 2'd2, 5'd7,  4'h3},
    {1'b0, 2'd0, 2'd2, 2'd2, 5'd7,  4'hC},
    {1'b0, 2'd1, 2'd1, 2'd0, 5'd0,  4'h0},
    {1'b0, 2'd1, 2'd1, 2'd0, 5'd19, 4'h0},
    {1'b0, 2'd1, 2'd1, 2'd3, 5'd19, 4'h0},
    {1'b0, 2'd1, 2'd1, 2'd2, 5'd7,  4'h0},
    {1'b0, 2'd1, 2'd2, 2'd2, 5'd7,  4'h0},
    {1'b0, 2'd2, 2'd1, 2'd0, 5'd0,  4'h9},
    {1'b0, 2'd2, 2'd0, 2'd0, 5'd0,  4'h6},
    {1'b0, 2'd1, 2'd1, 2'd1, 5'd1,  4'h0},
    {1'b0, 2'd0, 2'd1, 2'd0, 5'd21, 4'h7},
    {1'b0, 2'd1, 2'd1, 2'd1, 5'd1,  4'h0},
    {1'b0, 2'd1, 2'd1, 2'd0, 5'd21, 4'h0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one eight-phase bus cycle with sync; samples the read drive in phase 5
  task automatic busCycle(input logic [3:0] hi, input logic [3:0] lo,
                          input logic [3:0] d5, input logic [3:0] d6,
                          output logic oe, output logic [3:0] val);
    oe = 1'b0;
    val = 4'h0;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      syncIn = (p == 0);
      case (p)
        3: busIn = hi;
        4: busIn = lo;
        5: busIn = d5;
        6: busIn = d6;
        default: busIn = 4'h0;
      endcase
      if (p < 3) refModel = (refModel + 1) % 4;
      #1;
      if (p == 5) begin
        oe = busOe;
        val = busOut;
      end
    end
  endtask

  task automatic doSelect(input logic [1:0] chip, input logic [1:0] word, input logic [4:0] dig);
    logic o;
    logic [3:0] v;
    busCycle(4'h2, {chip, word}, dig[3:0], {3'b000, dig[4]}, o, v);
  endtask

  logic       oeS;
  logic [3:0] valS;
  logic       done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 80; i++) refMem[i] = 4'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R9 portOut after reset", portOut, 0);
    check("R9 busOe after reset", busOe, 0);
    check("R9 refreshRow after reset", refreshRow, 0);

    // R1: port-write pattern with no sync pulse, strap matches reset selection
    chipNum = 2'd0;
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      syncIn = 1'b0;
      busIn = (p % 8 == 3) ? 4'hE : (p % 8 == 4) ? 4'h1 : (p % 8 == 5) ? 4'h9 : 4'h0;
      #1;
      if (busOe) check("R1 drive before sync", busOe, 0);
    end
    check("R1 port unchanged before sync", portOut, 0);
    check("R1 refresh still before sync", refreshRow, 0);

    // R9: reset selection is chip 0, word 0, digit 0
    busCycle(4'hE, 4'h1, 4'h9, 4'h0, oeS, valS);
    check("R9 port via reset selection", portOut, 4'h9);
    busCycle(4'hE, 4'h0, 4'h4, 4'h0, oeS, valS);
    busCycle(4'hE, 4'h9, 4'h0, 4'h0, oeS, valS);
    check("R9 read oe via reset selection", oeS, 1);
    check("R9 read reset-selected digit", valS, 4'h4);
    check("R8 refresh after 3 cycles", refreshRow, refModel);

    // clear that digit and restore port model, then switch strap
    busCycle(4'hE, 4'h0, 4'h0, 4'h0, oeS, valS);
    refPort = 4'h9;
    chipNum = 2'd1;

    // table walk: select then command, model updated from the requirements
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] op, ch, wd;
      logic [4:0] dg;
      logic [3:0] dt;
      logic hit, inR;
      int idx;
      {op, ch, wd, dg, dt} = VEC[k][14:0];
      hit = (ch == chipNum);
      inR = (dg < 5'd20);
      idx = int'(wd) * 20 + int'(dg);
      doSelect(ch, wd, dg);
      case (op)
        2'd0: begin
          busCycle(4'hE, 4'h0, dt, 4'h0, oeS, valS);
          if (hit && inR) refMem[idx] = dt;
          check("R3 no drive on write", oeS, 0);
        end
        2'd1: begin
          busCycle(4'hE, 4'h9, 4'h0, 4'h0, oeS, valS);
          check(hit ? "R4 read drive" : "R6 foreign read drive", oeS, hit);
          check(hit ? (inR ? "R3 R4 read value" : "R7 out-of-range read") : "R6 foreign read value",
                valS, (hit && inR) ? refMem[idx] : 4'h0);
        end
        default: begin
          busCycle(4'hE, 4'h1, dt, 4'h0, oeS, valS);
          if (hit) refPort = dt;
          check(hit ? "R5 port write" : "R6 foreign port write", portOut, refPort);
        end
      endcase
    end
    check("R8 refresh after table", refreshRow, refModel);

    // R2 persistence and R10 unknown opcode
    doSelect(2'd1, 2'd3, 5'd16);
    busCycle(4'hE, 4'h0, 4'hB, 4'h0, oeS, valS);
    busCycle(4'h7, 4'h0, 4'h1, 4'h1, oeS, valS);
    busCycle(4'h7, 4'h1, 4'h2, 4'h0, oeS, valS);
    check("R10 port untouched by unknown opcode", portOut, refPort);
    busCycle(4'hE, 4'h9, 4'h0, 4'h0, oeS, valS);
    check("R2 R10 selection persists", valS, 4'hB);
    busCycle(4'hE, 4'h9, 4'h0, 4'h0, oeS, valS);
    check("R2 second read same cell", valS, 4'hB);
    // select with foreign chip field: this chip is deselected
    doSelect(2'd3, 2'd3, 5'd16);
    busCycle(4'hE, 4'h9, 4'h0, 4'h0, oeS, valS);
    check("R6 deselected by foreign select", oeS, 0);

    // R8 wrap over many cycles
    for (int c = 0; c < 9; c++) busCycle(4'h0, 4'h0, 4'h0, 4'h0, oeS, valS);
    check("R8 refresh wrap", refreshRow, refModel);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule